// File: doc/BRIEF.md
# I/O Address Translation Cache

This block keeps recently completed I/O address translations so that the translation engine in front of a device-facing memory management unit does not repeat a page table walk on every request. A lookup carries an I/O virtual address, a 24-bit device identifier, a 20-bit process identifier and a flag that says whether the process identifier is meaningful. One clock later the block reports hit or miss, together with the translated physical address and the read, write and user permissions.

The array is fully associative. Each entry holds one translation for a 4 KiB page, a 2 MiB superpage or a 1 GiB superpage. The walker installs its results through a fill port, which also carries the page size. Replacement first uses a free slot. When every slot is occupied, a rotating pointer chooses the slot to overwrite. Software maintenance commands reach the block through an invalidate port. That port can drop every entry, every entry of one device, or the entries of one device that cover one virtual page. A build parameter widens the virtual page number from the 27 bits of the single-stage three-level format to the 29 bits of the guest-physical form, where the top level index has two extra bits.

Top module: `iotlb_cache`

## Requirements
- R1: After reset every entry is empty: `lk_done_o` is low and any lookup returns a miss.
- R2: `lk_done_o` is high in exactly the cycle after a cycle with `lk_req_i` high, and low otherwise.
- R3: A 4 KiB entry (`fill_size_i` = 0) hits only when the device identifier matches, the process-valid flags are equal, the process identifiers are equal whenever the flag is set, and all virtual page bits (`iova[VPN_W+11:12]`) are equal. The result address is the stored page number followed by `iova[11:0]`.
- R4: A 2 MiB entry (`fill_size_i` = 1) ignores virtual page bits [8:0] in the compare. The result address takes `iova[20:0]` in its low 21 bits, and the stored page number bits [8:0] are discarded.
- R5: A 1 GiB entry (`fill_size_i` = 2) ignores virtual page bits [17:0] in the compare. The result address takes `iova[29:0]` in its low 30 bits.
- R6: On a hit, `lk_r_o`, `lk_w_o` and `lk_u_o` repeat the permission bits that were stored by the fill.
- R7: When several valid entries match one lookup, the result comes from the entry with the lowest index.
- R8: A fill writes the lowest-index empty slot when one exists. In that case no valid entry is lost.
- R9: A fill into a full array overwrites the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping at the last slot, only on such overwrites.
- R10: An invalidate with `inv_kind_i` = 0 empties every entry in one cycle.
- R11: An invalidate with `inv_kind_i` = 1 empties exactly the entries whose device identifier equals `inv_did_i`.
- R12: An invalidate with `inv_kind_i` = 2 empties the entries of device `inv_did_i` whose page, at its own size, covers `inv_vpn_i`. The process identifier is not considered.
- R13: On a miss, `lk_pa_o` and the three permission outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_did_i | input | 24 | Lookup device identifier |
| lk_pid_i | input | 20 | Lookup process identifier |
| lk_pidv_i | input | 1 | Lookup process identifier is valid |
| lk_iova_i | input | VPN_W+12 | I/O virtual address |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | PPN_W+12 | Translated physical address |
| lk_r_o | output | 1 | Read permission |
| lk_w_o | output | 1 | Write permission |
| lk_u_o | output | 1 | User permission |
| fill_i | input | 1 | Install one translation |
| fill_did_i | input | 24 | Fill device identifier |
| fill_pid_i | input | 20 | Fill process identifier |
| fill_pidv_i | input | 1 | Fill process identifier is valid |
| fill_vpn_i | input | VPN_W | Fill virtual page number |
| fill_ppn_i | input | PPN_W | Fill physical page number |
| fill_size_i | input | 2 | Page size: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fill_r_i | input | 1 | Fill read permission |
| fill_w_i | input | 1 | Fill write permission |
| fill_u_i | input | 1 | Fill user permission |
| inv_i | input | 1 | Invalidate request |
| inv_kind_i | input | 2 | 0 = all, 1 = one device, 2 = device and page |
| inv_did_i | input | 24 | Invalidate device identifier |
| inv_vpn_i | input | VPN_W | Invalidate virtual page number |

## Verification
The assertions watch the properties that hold on every cycle. They check that a result follows each request by exactly one cycle, that a miss carries zeros, that a full flush leaves nothing valid, that a fill always lands in a valid slot and that the rotating pointer moves only on overwrites. The selection among overlapping entries, the superpage address composition, the choice of slot and the reach of each invalidate kind only show up in the bench's directed scenarios. Those scenarios infer the contents of each slot from which lookups still hit after a known sequence of fills and invalidates.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

   typedef enum logic [1:0] {
      PG_4K = 2'd0,
      PG_2M = 2'd1,
      PG_1G = 2'd2
   } pg_size_e;

   typedef enum logic [1:0] {
      INV_ALL      = 2'd0,
      INV_DEVICE   = 2'd1,
      INV_DEV_PAGE = 2'd2
   } inv_kind_e;

   localparam int unsigned DID_W   = 24;
   localparam int unsigned PID_W   = 20;
   localparam int unsigned PG_OFS  = 12;
   localparam int unsigned LVL_W   = 9;

endpackage

// File: rtl/iotlb_pick.sv
module iotlb_pick #(
   parameter int unsigned N     = 8,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   if (N < 1) begin : g_bad_n
      $error("iotlb_pick: N must be at least 1");
   end

   always_comb begin
      idx_o = '0;
      any_o = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            idx_o = IDX_W'(i);
            any_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/iotlb_tag_cmp.sv
module iotlb_tag_cmp
   import iotlb_pkg::*;
#(
   parameter int unsigned VPN_W = 27
) (
   input  logic             e_valid_i,
   input  logic [DID_W-1:0] e_did_i,
   input  logic [PID_W-1:0] e_pid_i,
   input  logic             e_pidv_i,
   input  logic [VPN_W-1:0] e_vpn_i,
   input  pg_size_e         e_size_i,
   input  logic             use_pid_i,
   input  logic [DID_W-1:0] q_did_i,
   input  logic [PID_W-1:0] q_pid_i,
   input  logic             q_pidv_i,
   input  logic [VPN_W-1:0] q_vpn_i,
   output logic             match_o
);

   if (VPN_W < 2 * LVL_W + 1) begin : g_bad_vpn
      $error("iotlb_tag_cmp: VPN_W too small for two superpage levels");
   end

   logic [VPN_W-1:0] care;
   logic             vpn_ok;
   logic             pid_ok;

   always_comb begin
      care = '1;
      unique case (e_size_i)
         PG_2M:   care[LVL_W-1:0]     = '0;
         PG_1G:   care[2*LVL_W-1:0]   = '0;
         default: care                = '1;
      endcase
   end

   assign vpn_ok  = (((e_vpn_i ^ q_vpn_i) & care) == '0);
   assign pid_ok  = !use_pid_i ||
                    ((e_pidv_i == q_pidv_i) && (!q_pidv_i || (e_pid_i == q_pid_i)));
   assign match_o = e_valid_i && (e_did_i == q_did_i) && pid_ok && vpn_ok;

endmodule

// File: rtl/iotlb_compose.sv
module iotlb_compose
   import iotlb_pkg::*;
#(
   parameter int unsigned VPN_W = 27,
   parameter int unsigned PPN_W = 44,
   localparam int unsigned IOVA_W = VPN_W + PG_OFS,
   localparam int unsigned PA_W   = PPN_W + PG_OFS
) (
   input  logic [PPN_W-1:0]  ppn_i,
   input  pg_size_e          size_i,
   input  logic [IOVA_W-1:0] iova_i,
   output logic [PA_W-1:0]   pa_o
);

   if (PPN_W < 2 * LVL_W + 1) begin : g_bad_ppn
      $error("iotlb_compose: PPN_W too small for superpages");
   end

   localparam int unsigned SP1_BITS = PG_OFS + LVL_W;
   localparam int unsigned SP2_BITS = PG_OFS + 2 * LVL_W;

   logic [PA_W-1:0] pass_mask;
   logic [PA_W-1:0] iova_ext;
   logic [PA_W-1:0] page_base;

   always_comb begin
      pass_mask = '0;
      unique case (size_i)
         PG_2M:   pass_mask[SP1_BITS-1:0] = '1;
         PG_1G:   pass_mask[SP2_BITS-1:0] = '1;
         default: pass_mask[PG_OFS-1:0]   = '1;
      endcase
   end

   if (PA_W >= IOVA_W) begin : g_ext_wide
      assign iova_ext = {{(PA_W - IOVA_W){1'b0}}, iova_i};
   end else begin : g_ext_trunc
      assign iova_ext = iova_i[PA_W-1:0];
   end

   assign page_base = {ppn_i, {PG_OFS{1'b0}}};
   assign pa_o      = (page_base & ~pass_mask) | (iova_ext & pass_mask);

endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
   parameter int unsigned N     = 8,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     valid_i,
   input  logic             fill_i,
   output logic [IDX_W-1:0] slot_o
);

   logic [IDX_W-1:0] free_idx;
   logic             any_free;
   logic [IDX_W-1:0] ptr_q;
   logic             evict;

   iotlb_pick #(.N(N)) i_free_pick (
      .req_i (~valid_i),
      .idx_o (free_idx),
      .any_o (any_free)
   );

   assign evict  = fill_i && !any_free;
   assign slot_o = any_free ? free_idx : ptr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
      end else if (evict) begin
         if (ptr_q == IDX_W'(N - 1)) ptr_q <= '0;
         else                        ptr_q <= ptr_q + 1'b1;
      end
   end

   AST_PTR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !evict |=> $stable(ptr_q)) else $error("pointer moved without overwrite"); // R9
   AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(ptr_q) < N) else $error("pointer out of range"); // R9

endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
   import iotlb_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 8,
   parameter bit          STAGE2    = 1'b0,
   parameter int unsigned PPN_W     = 44,
   localparam int unsigned VPN_W  = STAGE2 ? 29 : 27,
   localparam int unsigned IOVA_W = VPN_W + 12,
   localparam int unsigned PA_W   = PPN_W + 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lk_req_i,
   input  logic [23:0]       lk_did_i,
   input  logic [19:0]       lk_pid_i,
   input  logic              lk_pidv_i,
   input  logic [IOVA_W-1:0] lk_iova_i,
   output logic              lk_done_o,
   output logic              lk_hit_o,
   output logic [PA_W-1:0]   lk_pa_o,
   output logic              lk_r_o,
   output logic              lk_w_o,
   output logic              lk_u_o,
   input  logic              fill_i,
   input  logic [23:0]       fill_did_i,
   input  logic [19:0]       fill_pid_i,
   input  logic              fill_pidv_i,
   input  logic [VPN_W-1:0]  fill_vpn_i,
   input  logic [PPN_W-1:0]  fill_ppn_i,
   input  logic [1:0]        fill_size_i,
   input  logic              fill_r_i,
   input  logic              fill_w_i,
   input  logic              fill_u_i,
   input  logic              inv_i,
   input  logic [1:0]        inv_kind_i,
   input  logic [23:0]       inv_did_i,
   input  logic [VPN_W-1:0]  inv_vpn_i
);

   localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

   if (N_ENTRIES < 1) begin : g_bad_entries
      $error("iotlb_cache: N_ENTRIES must be at least 1");
   end
   if (DID_W != 24 || PID_W != 20) begin : g_bad_ids
      $error("iotlb_cache: identifier widths do not match the port list");
   end

   // entry storage
   logic [N_ENTRIES-1:0] valid_q;
   logic [DID_W-1:0]     did_q  [N_ENTRIES];
   logic [PID_W-1:0]     pid_q  [N_ENTRIES];
   logic                 pidv_q [N_ENTRIES];
   logic [VPN_W-1:0]     vpn_q  [N_ENTRIES];
   logic [PPN_W-1:0]     ppn_q  [N_ENTRIES];
   pg_size_e             size_q [N_ENTRIES];
   logic [2:0]           perm_q [N_ENTRIES];

   logic [N_ENTRIES-1:0] lk_match;
   logic [N_ENTRIES-1:0] inv_match;
   logic [N_ENTRIES-1:0] inv_clear;
   logic [VPN_W-1:0]     lk_vpn;
   inv_kind_e            inv_kind;

   assign lk_vpn   = lk_iova_i[IOVA_W-1:PG_OFS];
   assign inv_kind = inv_kind_e'(inv_kind_i);

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
      iotlb_tag_cmp #(.VPN_W(VPN_W)) i_lk_cmp (
         .e_valid_i (valid_q[g]),
         .e_did_i   (did_q[g]),
         .e_pid_i   (pid_q[g]),
         .e_pidv_i  (pidv_q[g]),
         .e_vpn_i   (vpn_q[g]),
         .e_size_i  (size_q[g]),
         .use_pid_i (1'b1),
         .q_did_i   (lk_did_i),
         .q_pid_i   (lk_pid_i),
         .q_pidv_i  (lk_pidv_i),
         .q_vpn_i   (lk_vpn),
         .match_o   (lk_match[g])
      );

      iotlb_tag_cmp #(.VPN_W(VPN_W)) i_inv_cmp (
         .e_valid_i (valid_q[g]),
         .e_did_i   (did_q[g]),
         .e_pid_i   (pid_q[g]),
         .e_pidv_i  (pidv_q[g]),
         .e_vpn_i   (vpn_q[g]),
         .e_size_i  (size_q[g]),
         .use_pid_i (1'b0),
         .q_did_i   (inv_did_i),
         .q_pid_i   ('0),
         .q_pidv_i  (1'b0),
         .q_vpn_i   (inv_vpn_i),
         .match_o   (inv_match[g])
      );

      always_comb begin
         inv_clear[g] = 1'b0;
         if (inv_i) begin
            unique case (inv_kind)
               INV_ALL:      inv_clear[g] = 1'b1;
               INV_DEVICE:   inv_clear[g] = (did_q[g] == inv_did_i);
               INV_DEV_PAGE: inv_clear[g] = inv_match[g];
               default:      inv_clear[g] = 1'b0;
            endcase
         end
      end
   end

   // lookup: priority select, compose, register
   logic [IDX_W-1:0] hit_idx;
   logic             hit_any;
   logic [PA_W-1:0]  hit_pa;

   iotlb_pick #(.N(N_ENTRIES)) i_hit_pick (
      .req_i (lk_match),
      .idx_o (hit_idx),
      .any_o (hit_any)
   );

   iotlb_compose #(.VPN_W(VPN_W), .PPN_W(PPN_W)) i_compose (
      .ppn_i  (ppn_q[hit_idx]),
      .size_i (size_q[hit_idx]),
      .iova_i (lk_iova_i),
      .pa_o   (hit_pa)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lk_done_o <= 1'b0;
         lk_hit_o  <= 1'b0;
         lk_pa_o   <= '0;
         lk_r_o    <= 1'b0;
         lk_w_o    <= 1'b0;
         lk_u_o    <= 1'b0;
      end else begin
         lk_done_o <= lk_req_i;
         if (lk_req_i && hit_any) begin
            lk_hit_o <= 1'b1;
            lk_pa_o  <= hit_pa;
            {lk_r_o, lk_w_o, lk_u_o} <= perm_q[hit_idx];
         end else begin
            lk_hit_o <= 1'b0;
            lk_pa_o  <= '0;
            {lk_r_o, lk_w_o, lk_u_o} <= 3'b000;
         end
      end
   end

   // fill and invalidate
   logic [IDX_W-1:0] fill_slot;

   iotlb_victim #(.N(N_ENTRIES)) i_victim (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_q),
      .fill_i  (fill_i),
      .slot_o  (fill_slot)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < N_ENTRIES; i++) begin
            if (fill_i && (fill_slot == IDX_W'(i))) valid_q[i] <= 1'b1;
            else if (inv_clear[i])                   valid_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (fill_i && (fill_slot == IDX_W'(i))) begin
            did_q[i]  <= fill_did_i;
            pid_q[i]  <= fill_pid_i;
            pidv_q[i] <= fill_pidv_i;
            vpn_q[i]  <= fill_vpn_i;
            ppn_q[i]  <= fill_ppn_i;
            size_q[i] <= pg_size_e'(fill_size_i);
            perm_q[i] <= {fill_r_i, fill_w_i, fill_u_i};
         end
      end
   end

   AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_req_i |=> lk_done_o) else $error("missing lookup result"); // R2
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_req_i |=> !lk_done_o) else $error("result without request"); // R2
   AST_MISS_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_hit_o |-> (lk_pa_o == '0 && !lk_r_o && !lk_w_o && !lk_u_o))
      else $error("miss carries data"); // R13
   AST_EMPTY_MISSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_req_i && valid_q == '0) |=> !lk_hit_o) else $error("hit on empty array"); // R1
   AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inv_i && inv_kind == INV_ALL && !fill_i) |=> (valid_q == '0))
      else $error("flush left entries"); // R10
   AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_i |=> valid_q[$past(fill_slot)]) else $error("fill slot not valid"); // R8

endmodule

// File: tb/test_iotlb_cache.sv
module test_iotlb_cache;

   localparam int VPN_W = 27;
   localparam int PPN_W = 44;
   localparam int PA_W  = PPN_W + 12;
   localparam int IOVA_W = VPN_W + 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_req = 1'b0;
   logic [23:0]       lk_did = '0;
   logic [19:0]       lk_pid = '0;
   logic              lk_pidv = 1'b0;
   logic [IOVA_W-1:0] lk_iova = '0;
   logic              lk_done, lk_hit, lk_r, lk_w, lk_u;
   logic [PA_W-1:0]   lk_pa;
   logic              fill = 1'b0;
   logic [23:0]       fill_did = '0;
   logic [19:0]       fill_pid = '0;
   logic              fill_pidv = 1'b0;
   logic [VPN_W-1:0]  fill_vpn = '0;
   logic [PPN_W-1:0]  fill_ppn = '0;
   logic [1:0]        fill_size = '0;
   logic              fill_r = 1'b0, fill_w = 1'b0, fill_u = 1'b0;
   logic              inv = 1'b0;
   logic [1:0]        inv_kind = '0;
   logic [23:0]       inv_did = '0;
   logic [VPN_W-1:0]  inv_vpn = '0;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   iotlb_cache i_iotlb_cache (
      .clk_i(clk), .rst_ni(rst_n),
      .lk_req_i(lk_req), .lk_did_i(lk_did), .lk_pid_i(lk_pid), .lk_pidv_i(lk_pidv),
      .lk_iova_i(lk_iova), .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_pa_o(lk_pa),
      .lk_r_o(lk_r), .lk_w_o(lk_w), .lk_u_o(lk_u),
      .fill_i(fill), .fill_did_i(fill_did), .fill_pid_i(fill_pid), .fill_pidv_i(fill_pidv),
      .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn), .fill_size_i(fill_size),
      .fill_r_i(fill_r), .fill_w_i(fill_w), .fill_u_i(fill_u),
      .inv_i(inv), .inv_kind_i(inv_kind), .inv_did_i(inv_did), .inv_vpn_i(inv_vpn)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_fill(logic [23:0] did, logic [19:0] pid, logic pidv,
                          logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn,
                          logic [1:0] size, logic [2:0] perm);
      @(negedge clk);
      fill = 1'b1; fill_did = did; fill_pid = pid; fill_pidv = pidv;
      fill_vpn = vpn; fill_ppn = ppn; fill_size = size;
      {fill_r, fill_w, fill_u} = perm;
      @(negedge clk);
      fill = 1'b0;
   endtask

   task automatic do_inv(logic [1:0] kind, logic [23:0] did, logic [VPN_W-1:0] vpn);
      @(negedge clk);
      inv = 1'b1; inv_kind = kind; inv_did = did; inv_vpn = vpn;
      @(negedge clk);
      inv = 1'b0;
   endtask

   // lookup and compare all outputs; exp_pa and exp_perm are zero on a miss (R13)
   task automatic expect_lk(string req, logic [23:0] did, logic [19:0] pid, logic pidv,
                            logic [IOVA_W-1:0] iova, logic exp_hit,
                            logic [PA_W-1:0] exp_pa, logic [2:0] exp_perm);
      @(negedge clk);
      lk_req = 1'b1; lk_did = did; lk_pid = pid; lk_pidv = pidv; lk_iova = iova;
      @(negedge clk);
      lk_req = 1'b0;
      check({req, " done"}, 64'(lk_done), 64'(1'b1));
      check({req, " hit"},  64'(lk_hit), 64'(exp_hit));
      check({req, " pa"},   64'(lk_pa), 64'(exp_hit ? exp_pa : '0));
      check({req, " perm"}, 64'({lk_r, lk_w, lk_u}), 64'(exp_hit ? exp_perm : 3'b000));
   endtask

   function automatic logic [IOVA_W-1:0] va(logic [VPN_W-1:0] vpn, logic [11:0] ofs);
      return {vpn, ofs};
   endfunction

   function automatic logic [PA_W-1:0] pa4k(logic [PPN_W-1:0] ppn, logic [IOVA_W-1:0] iova);
      return {ppn, iova[11:0]};
   endfunction

   task automatic t_reset();
      check("R1 done idle after reset", 64'(lk_done), 64'(0));
      expect_lk("R1 empty miss", 24'h5, 20'h7, 1'b1, va(27'h12345, 12'h0), 1'b0, '0, 3'b0);
      @(negedge clk);
      check("R2 done low without request", 64'(lk_done), 64'(0));
   endtask

   task automatic t_basic_4k();
      logic [IOVA_W-1:0] a;
      a = va(27'h12345, 12'h3c4);
      do_inv(2'd0, '0, '0);
      do_fill(24'h5, 20'h7, 1'b1, 27'h12345, 44'hABCDE, 2'd0, 3'b101);
      expect_lk("R3 R6 4K hit", 24'h5, 20'h7, 1'b1, a, 1'b1, pa4k(44'hABCDE, a), 3'b101);
      expect_lk("R3 pid mismatch", 24'h5, 20'h8, 1'b1, a, 1'b0, '0, 3'b0);
      expect_lk("R3 pidv mismatch", 24'h5, 20'h7, 1'b0, a, 1'b0, '0, 3'b0);
      expect_lk("R3 did mismatch", 24'h6, 20'h7, 1'b1, a, 1'b0, '0, 3'b0);
      expect_lk("R3 R13 next page miss", 24'h5, 20'h7, 1'b1, va(27'h12346, 12'h3c4),
                1'b0, '0, 3'b0);
      do_fill(24'h5, 20'h0, 1'b0, 27'h00777, 44'h123, 2'd0, 3'b010);
      expect_lk("R3 R6 no-pid hit", 24'h5, 20'h3, 1'b0, va(27'h00777, 12'hfff), 1'b1,
                {44'h123, 12'hfff}, 3'b010);
   endtask

   task automatic t_super();
      logic [IOVA_W-1:0] a;
      logic [PPN_W-1:0]  p;
      do_inv(2'd0, '0, '0);
      p = 44'h5555;
      do_fill(24'h2, 20'h0, 1'b0, 27'h40000, p, 2'd1, 3'b110);
      a = va(27'h4007F, 12'hABC);
      expect_lk("R4 2M hit", 24'h2, 20'h0, 1'b0, a, 1'b1,
                PA_W'((p >> 9) << 21) | PA_W'(a[20:0]), 3'b110);
      expect_lk("R4 2M outside", 24'h2, 20'h0, 1'b0, va(27'h40200, 12'h0), 1'b0, '0, 3'b0);
      p = 44'hF_0003_1234;
      do_fill(24'h3, 20'h0, 1'b0, 27'hC0000, p, 2'd2, 3'b100);
      a = va(27'hC1234, 12'h567);
      expect_lk("R5 1G hit", 24'h3, 20'h0, 1'b0, a, 1'b1,
                PA_W'((p >> 18) << 30) | PA_W'(a[29:0]), 3'b100);
      a = va(27'hFFFFF, 12'h001);
      expect_lk("R5 1G top of range", 24'h3, 20'h0, 1'b0, a, 1'b1,
                PA_W'((p >> 18) << 30) | PA_W'(a[29:0]), 3'b100);
      expect_lk("R5 1G outside", 24'h3, 20'h0, 1'b0, va(27'h100000, 12'h0), 1'b0, '0, 3'b0);
   endtask

   task automatic t_multi();
      logic [IOVA_W-1:0] a;
      do_inv(2'd0, '0, '0);
      do_fill(24'h9, 20'h0, 1'b0, 27'h200, 44'h8000, 2'd1, 3'b111);
      do_fill(24'h9, 20'h0, 1'b0, 27'h201, 44'h4444, 2'd0, 3'b001);
      a = va(27'h201, 12'h010);
      expect_lk("R7 lowest index is 2M", 24'h9, 20'h0, 1'b0, a, 1'b1,
                PA_W'((44'h8000 >> 9) << 21) | PA_W'(a[20:0]), 3'b111);
      do_inv(2'd0, '0, '0);
      do_fill(24'h9, 20'h0, 1'b0, 27'h201, 44'h4444, 2'd0, 3'b001);
      do_fill(24'h9, 20'h0, 1'b0, 27'h200, 44'h8000, 2'd1, 3'b111);
      expect_lk("R7 lowest index is 4K", 24'h9, 20'h0, 1'b0, a, 1'b1,
                pa4k(44'h4444, a), 3'b001);
   endtask

   task automatic hit_vpn(string req, logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn, logic h);
      expect_lk(req, 24'h1, 20'h0, 1'b0, va(vpn, 12'h008), h, {ppn, 12'h008}, 3'b100);
   endtask

   task automatic t_repl();
      do_inv(2'd0, '0, '0);
      for (int i = 0; i < 8; i++)
         do_fill(24'h1, 20'h0, 1'b0, 27'h1000 + 27'(i), 44'h100 + 44'(i), 2'd0, 3'b100);
      for (int i = 0; i < 8; i++)
         hit_vpn("R8 all fills kept", 27'h1000 + 27'(i), 44'h100 + 44'(i), 1'b1);
      do_fill(24'h1, 20'h0, 1'b0, 27'h2000, 44'h200, 2'd0, 3'b100);
      hit_vpn("R9 slot0 evicted", 27'h1000, 44'h100, 1'b0);
      hit_vpn("R9 slot1 kept", 27'h1001, 44'h101, 1'b1);
      hit_vpn("R9 new entry", 27'h2000, 44'h200, 1'b1);
      do_fill(24'h1, 20'h0, 1'b0, 27'h2001, 44'h201, 2'd0, 3'b100);
      hit_vpn("R9 slot1 evicted", 27'h1001, 44'h101, 1'b0);
      hit_vpn("R9 slot2 kept", 27'h1002, 44'h102, 1'b1);
      do_inv(2'd2, 24'h1, 27'h1004);
      hit_vpn("R12 page dropped", 27'h1004, 44'h104, 1'b0);
      hit_vpn("R12 neighbour kept", 27'h1005, 44'h105, 1'b1);
      do_fill(24'h1, 20'h0, 1'b0, 27'h2002, 44'h202, 2'd0, 3'b100);
      hit_vpn("R8 refill free slot", 27'h2002, 44'h202, 1'b1);
      hit_vpn("R8 slot2 survives", 27'h1002, 44'h102, 1'b1);
      hit_vpn("R8 slot3 survives", 27'h1003, 44'h103, 1'b1);
      hit_vpn("R8 slot7 survives", 27'h1007, 44'h107, 1'b1);
      hit_vpn("R8 earlier fill survives", 27'h2000, 44'h200, 1'b1);
      do_fill(24'h1, 20'h0, 1'b0, 27'h2003, 44'h203, 2'd0, 3'b100);
      hit_vpn("R9 pointer at slot2", 27'h1002, 44'h102, 1'b0);
      hit_vpn("R9 slot3 kept after", 27'h1003, 44'h103, 1'b1);
   endtask

   task automatic t_inv();
      do_inv(2'd0, '0, '0);
      do_fill(24'h1, 20'h0, 1'b0, 27'h0A0, 44'h10, 2'd0, 3'b100);
      do_fill(24'h2, 20'h0, 1'b0, 27'h0B0, 44'h20, 2'd0, 3'b100);
      do_fill(24'h1, 20'h4, 1'b1, 27'h400, 44'h30, 2'd1, 3'b100);
      do_fill(24'h3, 20'h5, 1'b1, 27'h600, 44'h4000, 2'd1, 3'b100);
      do_inv(2'd1, 24'h1, '0);
      expect_lk("R11 dev1 4K gone", 24'h1, 20'h0, 1'b0, va(27'h0A0, 12'h0), 1'b0, '0, 3'b0);
      expect_lk("R11 dev1 2M gone", 24'h1, 20'h4, 1'b1, va(27'h400, 12'h0), 1'b0, '0, 3'b0);
      expect_lk("R11 dev2 kept", 24'h2, 20'h0, 1'b0, va(27'h0B0, 12'h1), 1'b1,
                {44'h20, 12'h1}, 3'b100);
      do_inv(2'd2, 24'h3, 27'h655);
      expect_lk("R12 2M covered page gone", 24'h3, 20'h5, 1'b1, va(27'h600, 12'h0),
                1'b0, '0, 3'b0);
      do_inv(2'd0, '0, '0);
      expect_lk("R10 flush all", 24'h2, 20'h0, 1'b0, va(27'h0B0, 12'h1), 1'b0, '0, 3'b0);
   endtask

   initial begin
      #(4ns * 200000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_4k();
      t_super();
      t_multi();
      t_repl();
      t_inv();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule